// File: doc/BRIEF.md
# Power-Up Reset Sequencer

This block produces the internal reset of a small microcontroller core. An analog detector outside the block delivers a power-on pulse. That pulse forces the reset output active at once, arms a reset latch and zeroes a start-up timer. The latch stays set until the timer has counted a programmable number of timer-clock cycles. Only then does the core leave reset.

The timer counts only while the effective master-clear level is high. That level comes from one of two sources, chosen by a configuration bit:

- **Bit set:** the level comes from an external active-low pin. The pin passes through a two-stage synchronizer first.
- **Bit cleared:** the master clear is tied high inside the block. A flag then tells the pin multiplexer that the shared pin is a general-purpose input.

Whenever the effective master clear is low, the timer is held at zero and the latch is set. So pulling the pin low during a count, or after the core is running, restarts the whole sequence.

The reset output is asserted asynchronously by the power-on pulse. It is released synchronously on a timer-clock edge. The time-out is a parameter given in timer-clock cycles.

Top module: `pwrup_rst_ctrl`

## Requirements
- R1: While `por_i` is high, `core_rst_o` is 1 immediately, without waiting for a clock edge.
- R2: `pin_is_gpio_o` is 1 when `mclr_sel_i` is 0 and is 0 when `mclr_sel_i` is 1.
- R3: With `mclr_sel_i` = 1, `core_rst_o` falls on exactly the (STARTUP_CYCLES+2)-th rising edge of `clk_i`, counting from the first edge that samples `mclr_pin_n_i` high. The extra two edges are the synchronizer delay.
- R4: With `mclr_sel_i` = 0, `core_rst_o` falls on the STARTUP_CYCLES-th rising edge after `por_i` drops, and `mclr_pin_n_i` has no effect on `core_rst_o` at any time.
- R5: With `mclr_sel_i` = 1, `core_rst_o` stays 1 for as long as `mclr_pin_n_i` is held low after power-on, however long that is.
- R6: If `mclr_pin_n_i` goes low for at least three cycles during a count, the count restarts. Release then follows R3, measured from the pin's return to high.
- R7: With `mclr_sel_i` = 1 and the core running, driving `mclr_pin_n_i` low sets `core_rst_o` on the third rising edge that samples the pin low.
- R8: `core_rst_o` is never released unless the effective master clear was high in the cycle before the release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running start-up timer clock |
| por_i | input | 1 | Power-on pulse from the supply detector, active high, asynchronous |
| mclr_pin_n_i | input | 1 | External master-clear pin, active low, asynchronous |
| mclr_sel_i | input | 1 | Configuration bit: 1 uses the pin as master clear, 0 ties master clear high |
| core_rst_o | output | 1 | Internal chip reset, active high |
| pin_is_gpio_o | output | 1 | 1 when the shared pin is free for general-purpose input |

## Verification
The results fall due at different times:

- The reset output rises in the same cycle as the power-on pulse.
- The GPIO flag follows the configuration bit without delay.
- In pin mode, release falls due STARTUP_CYCLES+2 edges after the first edge that samples the pin high. In tie-high mode it falls due STARTUP_CYCLES edges after the power-on pulse ends.
- A running core re-enters reset on the third edge after the pin goes low.

The bench drives every input at a falling edge and counts rising edges from that point. It checks the output at the falling edge after the last expected edge and again one edge earlier. A release that comes one cycle early or one cycle late therefore fails.

// File: rtl/pwrup_pkg.sv
package pwrup_pkg;

  // Width of a counter that must hold values 0 .. limit.
  function automatic int unsigned cnt_width(input int unsigned limit);
    int unsigned w;
    w = 1;
    while ((2 ** w) <= limit) w++;
    return w;
  endfunction

  // Edges from the first edge that sees the pin high to the release edge.
  function automatic int unsigned release_edges(input bit pin_mode,
                                                input int unsigned sync_stages,
                                                input int unsigned startup);
    return pin_mode ? (startup + sync_stages) : startup;
  endfunction

  // Number of synchronizer stages used by the master-clear path.
  localparam int unsigned MCLR_SYNC_STAGES = 2;

endpackage

// File: rtl/mclr_sync.sv
module mclr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic por_i,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  // The chain clears to 0 on power-on, so the pin reads "held low" until sampled.
  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i) chain_q <= '0;
    else       chain_q <= {chain_q[STAGES-2:0], async_i};
  end

  assign sync_o = chain_q[STAGES-1];

  // R3: the output moves only to a value the chain held one cycle before
  sync_follow_chk: assert property (@(posedge clk_i) disable iff (por_i)
    $rose(sync_o) |-> $past(chain_q[STAGES-2]));

endmodule

// File: rtl/mclr_source_sel.sv
module mclr_source_sel (
  input  logic pin_mode_i,
  input  logic pin_level_i,
  output logic mclr_eff_o,
  output logic pin_is_gpio_o
);
  always_comb begin
    if (pin_mode_i) begin
      mclr_eff_o    = pin_level_i;
      pin_is_gpio_o = 1'b0;
    end else begin
      mclr_eff_o    = 1'b1;
      pin_is_gpio_o = 1'b1;
    end
  end
endmodule

// File: rtl/drt_counter.sv
module drt_counter #(
  parameter int unsigned STARTUP_CYCLES = 18000
) (
  input  logic clk_i,
  input  logic por_i,
  input  logic run_i,
  input  logic clear_i,
  output logic timeout_o
);
  import pwrup_pkg::*;

  localparam int unsigned CW = cnt_width(STARTUP_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(STARTUP_CYCLES - 1);

  logic [CW-1:0] count_q;
  logic          at_last;

  assign at_last   = (count_q == LAST);
  assign timeout_o = run_i && !clear_i && at_last;

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i)                 count_q <= '0;
    else if (clear_i)          count_q <= '0;
    else if (timeout_o)        count_q <= '0;
    else if (run_i)            count_q <= count_q + 1'b1;
  end

  // R6
  clear_zero_chk: assert property (@(posedge clk_i) disable iff (por_i)
    clear_i |=> (count_q == '0));

  // R3
  no_overrun_chk: assert property (@(posedge clk_i) disable iff (por_i)
    count_q <= LAST);

  // R5
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (por_i)
    (!run_i && !clear_i) |=> $stable(count_q));

endmodule

// File: rtl/reset_latch.sv
module reset_latch (
  input  logic clk_i,
  input  logic por_i,
  input  logic mclr_eff_i,
  input  logic timeout_i,
  output logic in_reset_o
);
  logic latch_q;

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i)            latch_q <= 1'b1;
    else if (!mclr_eff_i) latch_q <= 1'b1;
    else if (timeout_i)   latch_q <= 1'b0;
  end

  assign in_reset_o = latch_q;

  // R3
  timeout_release_chk: assert property (@(posedge clk_i) disable iff (por_i)
    timeout_i |=> !latch_q);

  // R7
  mclr_low_sets_chk: assert property (@(posedge clk_i) disable iff (por_i)
    !mclr_eff_i |=> latch_q);

endmodule

// File: rtl/pwrup_rst_ctrl.sv
module pwrup_rst_ctrl #(
  parameter int unsigned STARTUP_CYCLES = 18000
) (
  input  logic clk_i,
  input  logic por_i,
  input  logic mclr_pin_n_i,
  input  logic mclr_sel_i,
  output logic core_rst_o,
  output logic pin_is_gpio_o
);
  import pwrup_pkg::*;

  logic pin_synced;
  logic mclr_eff;
  logic in_reset;
  logic timeout_hit;
  logic count_run;
  logic count_clear;

  mclr_sync #(.STAGES(MCLR_SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .por_i   (por_i),
    .async_i (mclr_pin_n_i),
    .sync_o  (pin_synced)
  );

  mclr_source_sel u_sel (
    .pin_mode_i    (mclr_sel_i),
    .pin_level_i   (pin_synced),
    .mclr_eff_o    (mclr_eff),
    .pin_is_gpio_o (pin_is_gpio_o)
  );

  assign count_run   = in_reset && mclr_eff;
  assign count_clear = !mclr_eff;

  drt_counter #(.STARTUP_CYCLES(STARTUP_CYCLES)) u_drt (
    .clk_i     (clk_i),
    .por_i     (por_i),
    .run_i     (count_run),
    .clear_i   (count_clear),
    .timeout_o (timeout_hit)
  );

  reset_latch u_latch (
    .clk_i      (clk_i),
    .por_i      (por_i),
    .mclr_eff_i (mclr_eff),
    .timeout_i  (timeout_hit),
    .in_reset_o (in_reset)
  );

  assign core_rst_o = in_reset || por_i;

  // R8
  release_needs_mclr_chk: assert property (@(posedge clk_i) disable iff (por_i)
    $fell(core_rst_o) |-> $past(mclr_eff));

  // R7
  running_stays_chk: assert property (@(posedge clk_i) disable iff (por_i)
    (!core_rst_o && mclr_eff) |=> !core_rst_o);

  // R1
  always_comb begin
    if (por_i) por_forces_chk: assert (core_rst_o);
  end

endmodule

// File: tb/pwrup_rst_ctrl_test.sv
`timescale 1ns/1ps
module pwrup_rst_ctrl_test;
  localparam int T = 16;

  logic clk = 1'b0;
  logic por = 1'b1;
  logic pin_n = 1'b0;
  logic sel = 1'b1;
  logic rst, gpio;
  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  pwrup_rst_ctrl #(.STARTUP_CYCLES(T)) uut (
    .clk_i(clk), .por_i(por), .mclr_pin_n_i(pin_n), .mclr_sel_i(sel),
    .core_rst_o(rst), .pin_is_gpio_o(gpio)
  );

  // Each entry: [8] pin mode, [7:0] edges after power-on before the pin rises
  localparam logic [8:0] VEC [4] = '{9'h1_00, 9'h1_05, 9'h0_00, 9'h0_07};

  task automatic chk(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic power_on(input logic mode);
    @(negedge clk);
    sel = mode; pin_n = 1'b0; por = 1'b1;
    #2 chk(rst, 1'b1, "R1 reset asserted during power-on");
    @(negedge clk);
    por = 1'b0;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    // Reset state
    #3 chk(rst, 1'b1, "R1 reset at time zero");
    chk(gpio, 1'b0, "R2 pin mode flag");

    // Vector walk
    for (int v = 0; v < 4; v++) begin
      logic mode;
      int dly, e;
      mode = VEC[v][8];
      dly = int'(VEC[v][7:0]);
      e = mode ? dly + T + 2 : T;
      power_on(mode);
      chk(gpio, ~mode, "R2 gpio flag follows select");
      for (int k = 0; k < e; k++) begin
        if (k == dly) pin_n = 1'b1;
        @(negedge clk);
        if (k == e - 2) chk(rst, 1'b1, mode ? "R3 held one edge before" : "R4 held one edge before");
        if (k == e - 1) chk(rst, 1'b0, mode ? "R3 released on time" : "R4 released on time");
      end
    end

    // R5: pin held low keeps reset
    power_on(1'b1);
    edges(3 * T);
    chk(rst, 1'b1, "R5 pin held low keeps reset");

    // R6: pin low in mid count restarts the count
    pin_n = 1'b1;
    edges(8);
    pin_n = 1'b0;
    edges(3);
    pin_n = 1'b1;
    edges(T + 1);
    chk(rst, 1'b1, "R6 restarted count still running");
    edges(1);
    chk(rst, 1'b0, "R6 release after full count");

    // R7: re-assert while running
    pin_n = 1'b0;
    edges(2);
    chk(rst, 1'b0, "R7 not yet re-asserted after two edges");
    edges(1);
    chk(rst, 1'b1, "R7 re-asserted on third edge");

    // R4: pin ignored in tie-high mode
    power_on(1'b0);
    pin_n = 1'b0;
    edges(T);
    chk(rst, 1'b0, "R4 released despite pin low");
    edges(10);
    chk(rst, 1'b0, "R4 pin low ignored while running");
    chk(gpio, 1'b1, "R2 gpio flag in tie-high mode");

    summary();
  end
endmodule